// File: doc/BRIEF.md
# Three-Mode Interval Timer Channel

One timer channel built around a single 32-bit counter and one pin. A small configuration register selects one of three behaviours. In waveform mode the channel drives a periodic pulse on the pin. In capture mode it measures the width and the period of a pulse train that arrives on the pin. In event-watchdog mode it counts rising edges on the pin and reports whether enough of them arrive within a time window.

Period, pulse-width and count registers can be written from the bus and read back. In capture mode the channel overwrites the period and pulse-width registers with the values it measures. The channel reports its flags as a three-bit group. Each flag is cleared by writing a one to it. The bit positions are fixed, so several channels can be packed side by side into one shared status word.

The pin is split into input, output and output-enable signals. The pad ring joins them to the bidirectional pad. The incoming pin passes through a two-flop synchronizer before edges are detected.

Top module: `tri_mode_timer`

## Requirements
- R1: After reset, the count, period, pulse-width and configuration registers are zero. The status is 3'b000, and pin_oe_o and irq_o are low.
- R2: The configuration bits are: bit 0 enable, bits 2:1 mode (0 waveform, 1 capture, 2 watchdog, 3 idle), bit 3 interrupt enable. Bits 6:4 are stored but ignored. pin_oe_o is high only when the channel is enabled in waveform mode.
- R3: In waveform mode the counter starts at 1 on the cycle after enable, counts up once per clock, and reloads to 1 after reaching the period P. The pin is high while count <= pulse width W, so over any 2P clocks it is high for exactly 2W of them.
- R4: In waveform mode each reload at the period sets status bit 0.
- R5: In capture mode a synchronized rising edge saves the counter to the period register and restarts the count at 1. A falling edge saves the counter to the pulse-width register. Both values are in clock cycles, and the pin is not driven.
- R6: In capture mode a period capture sets status bit 0, and a width capture sets status bit 2.
- R7: In watchdog mode the counter counts synchronized rising edges. When the count reaches the period value before the window closes, status bit 0 is set, and both the edge count and the window restart.
- R8: In watchdog mode the window lasts pulse-width clocks. If it closes with fewer edges than the period value, status bit 2 is set, and both counts restart.
- R9: An increment of the counter from all ones wraps it to zero and sets status bit 1. The timer keeps counting.
- R10: A one written on stat_clr_i clears the matching status bit. A zero leaves that bit unchanged. A new set in the same cycle wins over the clear.
- R11: irq_o is high exactly when interrupt enable is set and status bit 0 is set.
- R12: When the channel is disabled, or set to idle mode, the counter holds its value unless the bus writes it, and the pin is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_i | input | 7 | Configuration write data |
| cnt_we_i | input | 1 | Count register write strobe |
| cnt_i | input | 32 | Count write data |
| per_we_i | input | 1 | Period register write strobe |
| per_i | input | 32 | Period write data |
| pw_we_i | input | 1 | Pulse-width register write strobe |
| pw_i | input | 32 | Pulse-width write data |
| stat_clr_i | input | 3 | Write-one-to-clear strobes for the status bits |
| pin_i | input | 1 | Pin input, asynchronous |
| pin_o | output | 1 | Pin output value |
| pin_oe_o | output | 1 | Pin output enable |
| cfg_o | output | 7 | Configuration register |
| cnt_o | output | 32 | Count register |
| per_o | output | 32 | Period register |
| pw_o | output | 32 | Pulse-width register |
| status_o | output | 3 | Status: bit 0 event, bit 1 overflow, bit 2 width/starve |
| irq_o | output | 1 | Interrupt request |

## Verification
The waveform test counts the high cycles over two whole periods. An off-by-one in the reload or in the `<=` compare therefore shows up as a wrong duty count. The capture test drives a pulse train 3 clocks high in every 8 and expects exactly 8 and 3 back. A design that restarted the count at 0, or captured on the wrong edge, would return 7, 9 or 5 instead.

The watchdog test first checks the event flag, then stops the edges and waits for the starve flag. A design whose window never expired, or whose two flags were swapped, fails here. Overflow is provoked by preloading the count near all ones. Single-bit clears and the idle and disabled holds catch a clear that wipes the whole status word and a counter that runs when it should not.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W  = 32;
  localparam int unsigned CFG_W  = 7;
  localparam int unsigned STAT_W = 3;

  localparam int unsigned CFG_EN  = 0;
  localparam int unsigned CFG_MLO = 1;
  localparam int unsigned CFG_IE  = 3;

  localparam int unsigned ST_EVT = 0;
  localparam int unsigned ST_OVF = 1;
  localparam int unsigned ST_AUX = 2;

  typedef enum logic [1:0] {
    M_WAVE = 2'd0,
    M_CAP  = 2'd1,
    M_WDOG = 2'd2,
    M_IDLE = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
  assign fall_o = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;

  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;
      else if (clr_i[i]) flag_q[i] <= 1'b0;
    end

    a_r10_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  tmr_mode_e    mode_i,
  input  logic         cnt_we_i,
  input  logic [W-1:0] cnt_i,
  input  logic         per_we_i,
  input  logic [W-1:0] per_i,
  input  logic         pw_we_i,
  input  logic [W-1:0] pw_i,
  input  logic         rise_i,
  input  logic         fall_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] per_o,
  output logic [W-1:0] pw_o,
  output logic         pin_o,
  output logic         pin_oe_o,
  output logic         evt_o,
  output logic         ovf_o,
  output logic         aux_o
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q, cnt_d, per_q, per_d, pw_q, pw_d, win_q, win_d;
  logic         en_q;
  logic         running, en_rise;
  logic [W-1:0] cnt_inc;

  assign running = en_i & en_q;
  assign en_rise = en_i & ~en_q;
  assign cnt_inc = cnt_q + ONE;

  always_comb begin
    cnt_d = cnt_q;
    per_d = per_q;
    pw_d  = pw_q;
    win_d = win_q;
    evt_o = 1'b0;
    ovf_o = 1'b0;
    aux_o = 1'b0;
    if (en_rise) begin
      cnt_d = (mode_i == M_WAVE) ? ONE : '0;
      win_d = '0;
    end else if (running) begin
      unique case (mode_i)
        M_WAVE: begin
          if (cnt_q >= per_q) begin
            cnt_d = ONE;
            evt_o = 1'b1;
          end else begin
            cnt_d = cnt_inc;
            ovf_o = (cnt_q == MAX);
          end
        end
        M_CAP: begin
          if (rise_i) begin
            per_d = cnt_q;
            cnt_d = ONE;
            evt_o = 1'b1;
          end else begin
            cnt_d = cnt_inc;
            ovf_o = (cnt_q == MAX);
          end
          if (fall_i) begin
            pw_d  = cnt_q;
            aux_o = 1'b1;
          end
        end
        M_WDOG: begin
          win_d = win_q + ONE;
          if (rise_i && (cnt_inc >= per_q) && (cnt_q != MAX)) begin
            evt_o = 1'b1;
            cnt_d = '0;
            win_d = '0;
          end else if (win_q >= pw_q) begin
            aux_o = 1'b1;
            cnt_d = '0;
            win_d = '0;
          end else if (rise_i) begin
            cnt_d = cnt_inc;
            ovf_o = (cnt_q == MAX);
          end
        end
        default: ;
      endcase
    end
    if (cnt_we_i) cnt_d = cnt_i;
    if (per_we_i) per_d = per_i;
    if (pw_we_i)  pw_d  = pw_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
      pw_q  <= '0;
      win_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
      pw_q  <= pw_d;
      win_q <= win_d;
      en_q  <= en_i;
    end
  end

  assign pin_oe_o = en_i && (mode_i == M_WAVE);
  assign pin_o    = running && (mode_i == M_WAVE) && (cnt_q != '0) && (cnt_q <= pw_q);
  assign cnt_o    = cnt_q;
  assign per_o    = per_q;
  assign pw_o     = pw_q;

  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cnt_we_i) |=> $stable(cnt_o));
  a_r12_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && mode_i == M_IDLE && !cnt_we_i) |=> $stable(cnt_o));
  a_r3_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && mode_i == M_WAVE && !cnt_we_i && cnt_o >= per_o) |=> (cnt_o == ONE));
  a_r5_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_CAP) |-> !pin_oe_o);
endmodule

// File: rtl/tri_mode_timer.sv
module tri_mode_timer
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              per_we_i,
  input  logic [CNT_W-1:0]  per_i,
  input  logic              pw_we_i,
  input  logic [CNT_W-1:0]  pw_i,
  input  logic [STAT_W-1:0] stat_clr_i,
  input  logic              pin_i,
  output logic              pin_o,
  output logic              pin_oe_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  per_o,
  output logic [CNT_W-1:0]  pw_o,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);
  logic [CFG_W-1:0]  cfg_q;
  logic              rise, fall, evt, ovf, aux;
  logic [STAT_W-1:0] st_set;
  tmr_mode_e         mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_i;
  end

  assign mode = tmr_mode_e'(cfg_q[CFG_MLO +: 2]);

  tmr_sync #(.STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  tmr_core #(.W(CNT_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cfg_q[CFG_EN]),
    .mode_i  (mode),
    .cnt_we_i(cnt_we_i),
    .cnt_i   (cnt_i),
    .per_we_i(per_we_i),
    .per_i   (per_i),
    .pw_we_i (pw_we_i),
    .pw_i    (pw_i),
    .rise_i  (rise),
    .fall_i  (fall),
    .cnt_o   (cnt_o),
    .per_o   (per_o),
    .pw_o    (pw_o),
    .pin_o   (pin_o),
    .pin_oe_o(pin_oe_o),
    .evt_o   (evt),
    .ovf_o   (ovf),
    .aux_o   (aux)
  );

  always_comb begin
    st_set         = '0;
    st_set[ST_EVT] = evt;
    st_set[ST_OVF] = ovf;
    st_set[ST_AUX] = aux;
  end

  tmr_status #(.W(STAT_W)) u_stat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (st_set),
    .clr_i (stat_clr_i),
    .flag_o(status_o)
  );

  assign cfg_o = cfg_q;
  assign irq_o = cfg_q[CFG_IE] & status_o[ST_EVT];

  a_r9_overflow_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> status_o[ST_OVF]);
  a_r4_event_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> status_o[ST_EVT]);
endmodule

// File: tb/tri_mode_timer_test.sv
module tri_mode_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 0, cnt_we = 0, per_we = 0, pw_we = 0;
  logic [6:0]  cfg_d = '0;
  logic [31:0] cnt_d = '0, per_d = '0, pw_d = '0;
  logic [2:0]  clr = '0;
  logic        pin_in = 1'b0;
  logic        pin_out, pin_oe, irq;
  logic [6:0]  cfg_rd;
  logic [31:0] cnt_rd, per_rd, pw_rd;
  logic [2:0]  status;
  int          errors = 0, checks = 0;

  always #5 clk = ~clk;

  tri_mode_timer uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_i(cfg_d),
    .cnt_we_i(cnt_we), .cnt_i(cnt_d),
    .per_we_i(per_we), .per_i(per_d),
    .pw_we_i(pw_we), .pw_i(pw_d),
    .stat_clr_i(clr), .pin_i(pin_in),
    .pin_o(pin_out), .pin_oe_o(pin_oe), .cfg_o(cfg_rd),
    .cnt_o(cnt_rd), .per_o(per_rd), .pw_o(pw_rd),
    .status_o(status), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(logic [6:0] v);
    @(negedge clk); cfg_we = 1; cfg_d = v; @(negedge clk); cfg_we = 0;
  endtask
  task automatic wr_cnt(logic [31:0] v);
    @(negedge clk); cnt_we = 1; cnt_d = v; @(negedge clk); cnt_we = 0;
  endtask
  task automatic wr_per(logic [31:0] v);
    @(negedge clk); per_we = 1; per_d = v; @(negedge clk); per_we = 0;
  endtask
  task automatic wr_pw(logic [31:0] v);
    @(negedge clk); pw_we = 1; pw_d = v; @(negedge clk); pw_we = 0;
  endtask
  task automatic w1c(logic [2:0] v);
    @(negedge clk); clr = v; @(negedge clk); clr = '0;
  endtask

  task automatic test_reset();
    check("R1 cnt", cnt_rd, 0);
    check("R1 per", per_rd, 0);
    check("R1 pw", pw_rd, 0);
    check("R1 cfg", {25'd0, cfg_rd}, 0);
    check("R1 status", {29'd0, status}, 0);
    check("R1 oe", {31'd0, pin_oe}, 0);
    check("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic test_wave();
    int highs = 0;
    wr_per(5); wr_pw(2);
    wr_cfg(7'b111_0001);
    tick(3);
    check("R2 oe in waveform", {31'd0, pin_oe}, 1);
    for (int i = 0; i < 10; i++) begin
      if (pin_out) highs++;
      tick(1);
    end
    check("R3 high cycles in 2P", highs, 4);
    check("R4 period event", {31'd0, status[0]}, 1);
    check("R11 irq masked", {31'd0, irq}, 0);
    wr_cfg(7'b000_1001);
    tick(1);
    check("R11 irq enabled", {31'd0, irq}, 1);
    wr_cfg(7'b000_0000);
    w1c(3'b111);
  endtask

  task automatic test_hold();
    logic [31:0] snap;
    tick(1);
    snap = cnt_rd;
    tick(8);
    check("R12 disabled hold", cnt_rd, snap);
    check("R12 disabled no drive", {31'd0, pin_oe}, 0);
    wr_cfg(7'b000_0111);
    tick(2);
    snap = cnt_rd;
    tick(8);
    check("R12 idle hold", cnt_rd, snap);
    check("R12 idle no drive", {31'd0, pin_oe}, 0);
    wr_cfg(7'b000_0000);
  endtask

  task automatic test_capture();
    wr_cfg(7'b000_0011);
    check("R5 capture no drive", {31'd0, pin_oe}, 0);
    for (int p = 0; p < 4; p++) begin
      pin_in = 1; tick(3);
      pin_in = 0; tick(5);
    end
    tick(6);
    check("R5 period captured", per_rd, 8);
    check("R5 width captured", pw_rd, 3);
    check("R6 period flag", {31'd0, status[0]}, 1);
    check("R6 width flag", {31'd0, status[2]}, 1);
    w1c(3'b101);
    check("R10 cleared both", {29'd0, status}, 0);
  endtask

  task automatic test_overflow();
    logic [31:0] a;
    wr_cnt(32'hFFFF_FFFD);
    tick(6);
    check("R9 overflow flag", {31'd0, status[1]}, 1);
    a = cnt_rd;
    tick(3);
    check("R9 still counting", cnt_rd, a + 3);
    w1c(3'b001);
    check("R10 zero leaves bit", {31'd0, status[1]}, 1);
    w1c(3'b010);
    check("R10 one clears bit", {31'd0, status[1]}, 0);
    wr_cfg(7'b000_0000);
  endtask

  task automatic test_watchdog();
    wr_per(3); wr_pw(50);
    w1c(3'b111);
    wr_cfg(7'b000_0101);
    for (int e = 0; e < 3; e++) begin
      pin_in = 1; tick(3);
      pin_in = 0; tick(3);
    end
    tick(4);
    check("R7 edges reached count", {31'd0, status[0]}, 1);
    check("R8 no starve yet", {31'd0, status[2]}, 0);
    w1c(3'b111);
    tick(120);
    check("R8 window starved", {31'd0, status[2]}, 1);
    check("R7 no event without edges", {31'd0, status[0]}, 0);
    wr_cfg(7'b000_0000);
  endtask

  initial begin
    fork
      begin
        tick(3);
        test_reset();
        rst_n = 1;
        tick(2);
        test_wave();
        test_hold();
        test_capture();
        test_overflow_setup();
        test_watchdog();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic test_overflow_setup();
    pin_in = 0;
    wr_cfg(7'b000_0011);
    tick(2);
    test_overflow();
  endtask
endmodule